// File: doc/BRIEF.md
# Power-Down Clock Stop Sequencer

This block stops and restarts a set of clock outputs cleanly when an asynchronous, active-low power-down request changes. It runs on a fast sampling clock and treats every source clock it gates as a level input. Each single-ended output and each differential pair is parked on its own clock's edge, so no output is cut short. A registered acknowledge tells the oscillator and PLL control that every output has parked and the sources may be switched off.

The stop decision is qualified. The synchronized request must be low on two consecutive rising edges of the complement clock of the qualifying differential pair (pair 0). While a differential pair is stopped, it shows one of two parked states, chosen by a per-pair mode bit: either the true leg is driven high with the complement released, or both legs are undriven. Per-output enable bits from the register bank hold an output parked whatever the power-down state.

Top module: `pdn_clock_stop_seq`

## Requirements
- R1: During and right after reset, every single-ended output is 0, the acknowledge is 0, and every pair shows the true-high parked state: true value 1, true enable 1, complement value 0, complement enable 0.
- R2: The request passes through a two-stage synchronizer. A stop is decided only once the synchronized request has been low at two consecutive rising edges of pair 0's complement source. Any synchronized high value clears the count and withdraws the stop.
- R3: A running single-ended output whose stop is due (power-down decided or enable 0) keeps following its source until that source's next falling edge. From that edge on it is held at 0.
- R4: A running pair parks at the next falling edge of its complement source. While parked with mode bit 0, it shows true value 1 and true enable 1, with complement value 0 and complement enable 0.
- R5: While parked with mode bit 1 and the stop decision active, both legs of the pair have enable 0 and value 0. Bit j of the mode input belongs to pair j.
- R6: After the stop decision clears, each single-ended output restarts at the first rising edge of its source, and each pair restarts at the first rising edge of its complement, so the first phase is full width. A pair parked fully undriven returns to the true-high driven state in the first cycle after the decision clears.
- R7: The acknowledge is a register that is 1 exactly in the cycle after one in which the stop decision was active and every output (enabled or not) was parked. While it is 1, all single-ended outputs are 0.
- R8: An output whose enable bit is 0 parks at its next falling edge and stays parked regardless of the power-down request.
- R9: A running output presents its source's level one sampling-clock cycle after that level was sampled; a running pair drives both enables to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Asynchronous power-down request, active low |
| se_src | input | N_SE | Single-ended source clock levels |
| se_en | input | N_SE | Per-output enable, 1 = may run |
| dif_t_src | input | N_DIFF | True legs of the differential sources |
| dif_c_src | input | N_DIFF | Complement legs of the differential sources |
| dif_en | input | N_DIFF | Per-pair enable, 1 = may run |
| dif_mode | input | N_DIFF | Per-pair parked mode, 0 = true high, 1 = undriven |
| se_out | output | N_SE | Gated single-ended clocks |
| dif_t_out | output | N_DIFF | True-leg drive value |
| dif_c_out | output | N_DIFF | Complement-leg drive value |
| dif_t_oe | output | N_DIFF | True-leg drive enable |
| dif_c_oe | output | N_DIFF | Complement-leg drive enable |
| pd_ack | output | 1 | All outputs parked under a power-down decision |

## Verification
The sources run at unequal, unrelated periods, so each output parks and restarts at a different cycle. This tells per-output edge tracking apart from a shared stop point. A request pulse shorter than two complement periods separates real qualification from plain synchronization. A long request with all pairs in mode 0 and another with mixed modes separate the two parked states and the undriven-to-driven change at release. A phase with some enables cleared, and no request, shows that a disabled output stays parked while its neighbours run.

// File: rtl/pdn_seq_pkg.sv
package pdn_seq_pkg;

    typedef struct packed {
        logic t_val;
        logic c_val;
        logic t_oe;
        logic c_oe;
    } pair_drive_t;

    localparam pair_drive_t PAIR_TRUE_HIGH = '{t_val: 1'b1, c_val: 1'b0, t_oe: 1'b1, c_oe: 1'b0};
    localparam pair_drive_t PAIR_UNDRIVEN  = '{t_val: 1'b0, c_val: 1'b0, t_oe: 1'b0, c_oe: 1'b0};

    function automatic logic level_rose(input logic prev, input logic cur);
        return !prev && cur;
    endfunction

    function automatic logic level_fell(input logic prev, input logic cur);
        return prev && !cur;
    endfunction

    function automatic logic next_parked(input logic parked, input logic hold,
                                         input logic park_edge, input logic run_edge);
        if (parked)
            return !(!hold && run_edge);
        return hold && park_edge;
    endfunction

endpackage

// File: rtl/pdn_qualifier.sv
module pdn_qualifier
    import pdn_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_EDGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pd_n,
    input  logic qual_src,
    output logic stop_req
);
    localparam int CW = $clog2(QUAL_EDGES + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(QUAL_EDGES);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pd_s;
    logic                   qual_prev_q;
    logic [CW-1:0]          cnt_q;

    assign pd_s     = sync_q[SYNC_STAGES-1];
    assign stop_req = (cnt_q == CNT_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q      <= '1;
            qual_prev_q <= 1'b0;
            cnt_q       <= '0;
        end else begin
            sync_q      <= {sync_q[SYNC_STAGES-2:0], pd_n};
            qual_prev_q <= qual_src;
            if (pd_s)
                cnt_q <= '0;
            else if (level_rose(qual_prev_q, qual_src) && cnt_q != CNT_FULL)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: a synchronized high request withdraws the stop next cycle
    assert_release_clears_R2: assert property (@(posedge clk) disable iff (rst)
        pd_s |=> !stop_req);
    // R2: a stop appears only while the synchronized request is low
    assert_stop_needs_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_req) |-> $past(!pd_s));

endmodule

// File: rtl/pdn_se_gate.sv
module pdn_se_gate
    import pdn_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic src,
    input  logic en,
    input  logic stop_req,
    output logic out_q,
    output logic parked_d
);
    logic prev_q;
    logic parked_q;
    logic hold;

    assign hold     = stop_req || !en;
    assign parked_d = next_parked(parked_q, hold,
                                  level_fell(prev_q, src), level_rose(prev_q, src));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            parked_q <= 1'b1;
            out_q    <= 1'b0;
        end else begin
            prev_q   <= src;
            parked_q <= parked_d;
            out_q    <= src && !parked_d;
        end
    end

    assert_hold_low_R3: assert property (@(posedge clk) disable iff (rst)
        (parked_q && hold) |=> !out_q);
    assert_restart_full_R6: assert property (@(posedge clk) disable iff (rst)
        (parked_q && !hold && !prev_q && src) |=> out_q);
    assert_disabled_stays_R8: assert property (@(posedge clk) disable iff (rst)
        (parked_q && !en) |=> parked_q);

endmodule

// File: rtl/pdn_diff_gate.sv
module pdn_diff_gate
    import pdn_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        t_src,
    input  logic        c_src,
    input  logic        en,
    input  logic        mode,
    input  logic        stop_req,
    output pair_drive_t drive_q,
    output logic        parked_d
);
    logic prev_c_q;
    logic parked_q;
    logic hold;
    pair_drive_t drive_d;

    assign hold     = stop_req || !en;
    assign parked_d = next_parked(parked_q, hold,
                                  level_fell(prev_c_q, c_src), level_rose(prev_c_q, c_src));

    always_comb begin
        if (!parked_d)
            drive_d = '{t_val: t_src, c_val: c_src, t_oe: 1'b1, c_oe: 1'b1};
        else if (mode && stop_req)
            drive_d = PAIR_UNDRIVEN;
        else
            drive_d = PAIR_TRUE_HIGH;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_c_q <= 1'b0;
            parked_q <= 1'b1;
            drive_q  <= PAIR_TRUE_HIGH;
        end else begin
            prev_c_q <= c_src;
            parked_q <= parked_d;
            drive_q  <= drive_d;
        end
    end

    assert_true_high_park_R4: assert property (@(posedge clk) disable iff (rst)
        (parked_q && stop_req && !mode) |=> (drive_q.t_val && drive_q.t_oe && !drive_q.c_oe));
    assert_undriven_park_R5: assert property (@(posedge clk) disable iff (rst)
        (parked_q && stop_req && mode) |=> (!drive_q.t_oe && !drive_q.c_oe));
    assert_release_drives_R6: assert property (@(posedge clk) disable iff (rst)
        (parked_q && !stop_req) |=> drive_q.t_oe);

endmodule

// File: rtl/pdn_clock_stop_seq.sv
module pdn_clock_stop_seq
    import pdn_seq_pkg::*;
#(
    parameter int N_SE        = 4,
    parameter int N_DIFF      = 3,
    parameter int QUAL_PAIR   = 0,
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_EDGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_n,
    input  logic [N_SE-1:0]   se_src,
    input  logic [N_SE-1:0]   se_en,
    input  logic [N_DIFF-1:0] dif_t_src,
    input  logic [N_DIFF-1:0] dif_c_src,
    input  logic [N_DIFF-1:0] dif_en,
    input  logic [N_DIFF-1:0] dif_mode,
    output logic [N_SE-1:0]   se_out,
    output logic [N_DIFF-1:0] dif_t_out,
    output logic [N_DIFF-1:0] dif_c_out,
    output logic [N_DIFF-1:0] dif_t_oe,
    output logic [N_DIFF-1:0] dif_c_oe,
    output logic              pd_ack
);
    localparam int N_ALL = N_SE + N_DIFF;

    logic              stop_req;
    logic [N_ALL-1:0]  parked_all;
    pair_drive_t       pair_drv [N_DIFF];

    pdn_qualifier #(
        .SYNC_STAGES (SYNC_STAGES),
        .QUAL_EDGES  (QUAL_EDGES)
    ) u_qual (
        .clk      (clk),
        .rst      (rst),
        .pd_n     (pd_n),
        .qual_src (dif_c_src[QUAL_PAIR]),
        .stop_req (stop_req)
    );

    for (genvar i = 0; i < N_SE; i++) begin : g_se
        pdn_se_gate u_gate (
            .clk      (clk),
            .rst      (rst),
            .src      (se_src[i]),
            .en       (se_en[i]),
            .stop_req (stop_req),
            .out_q    (se_out[i]),
            .parked_d (parked_all[i])
        );
    end

    for (genvar j = 0; j < N_DIFF; j++) begin : g_pair
        pdn_diff_gate u_gate (
            .clk      (clk),
            .rst      (rst),
            .t_src    (dif_t_src[j]),
            .c_src    (dif_c_src[j]),
            .en       (dif_en[j]),
            .mode     (dif_mode[j]),
            .stop_req (stop_req),
            .drive_q  (pair_drv[j]),
            .parked_d (parked_all[N_SE+j])
        );
        assign dif_t_out[j] = pair_drv[j].t_val;
        assign dif_c_out[j] = pair_drv[j].c_val;
        assign dif_t_oe[j]  = pair_drv[j].t_oe;
        assign dif_c_oe[j]  = pair_drv[j].c_oe;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pd_ack <= 1'b0;
        else
            pd_ack <= stop_req && (&parked_all);
    end

    assert_ack_after_stop_R7: assert property (@(posedge clk) disable iff (rst)
        pd_ack |-> $past(stop_req));
    assert_ack_outputs_low_R7: assert property (@(posedge clk) disable iff (rst)
        pd_ack |-> (se_out == '0));

endmodule

// File: tb/pdn_clock_stop_seq_tb.sv
module pdn_clock_stop_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int ND = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pd_n = 1'b1;
    logic [NS-1:0] se_src = '0, se_en = '1, se_out;
    logic [ND-1:0] dif_t_src = '0, dif_c_src = '1, dif_en = '1, dif_mode = '0;
    logic [ND-1:0] dif_t_out, dif_c_out, dif_t_oe, dif_c_oe;
    logic pd_ack;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdn_clock_stop_seq u_dut (
        .clk(clk), .rst(rst), .pd_n(pd_n),
        .se_src(se_src), .se_en(se_en),
        .dif_t_src(dif_t_src), .dif_c_src(dif_c_src),
        .dif_en(dif_en), .dif_mode(dif_mode),
        .se_out(se_out), .dif_t_out(dif_t_out), .dif_c_out(dif_c_out),
        .dif_t_oe(dif_t_oe), .dif_c_oe(dif_c_oe), .pd_ack(pd_ack)
    );

    // source clocks with unequal half periods, changed away from the edge
    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        for (int i = 0; i < NS; i++) se_src[i] = ((cyc / (i + 2)) % 2) == 1;
        for (int j = 0; j < ND; j++) begin
            dif_t_src[j] = ((cyc / (j + 3)) % 2) == 1;
            dif_c_src[j] = !dif_t_src[j];
        end
    end

    // behavioural reference model
    int m_s1, m_s2, m_cnt, m_cprev0;
    int m_prev[NS + ND];
    int m_park[NS + ND];
    logic [NS-1:0] m_se;
    logic [ND-1:0] m_t, m_c, m_toe, m_coe;
    logic m_ack;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 1; m_s2 = 1; m_cnt = 0; m_cprev0 = 0;
            foreach (m_prev[k]) begin m_prev[k] = 0; m_park[k] = 1; end
            m_se = '0; m_t = '1; m_c = '0; m_toe = '1; m_coe = '0; m_ack = 1'b0;
        end else begin
            bit stop;
            bit all_parked;
            stop = (m_cnt >= 2);
            all_parked = 1;
            for (int k = 0; k < NS + ND; k++) begin
                int cur;
                bit holding;
                cur = (k < NS) ? int'(se_src[k]) : int'(dif_c_src[k - NS]);
                holding = stop || ((k < NS) ? !se_en[k] : !dif_en[k - NS]);
                if (m_park[k] == 1) begin
                    if (!holding && m_prev[k] == 0 && cur == 1) m_park[k] = 0;
                end else if (holding && m_prev[k] == 1 && cur == 0) begin
                    m_park[k] = 1;
                end
                m_prev[k] = cur;
                if (m_park[k] == 0) all_parked = 0;
            end
            for (int i = 0; i < NS; i++) m_se[i] = se_src[i] && (m_park[i] == 0);
            for (int j = 0; j < ND; j++) begin
                if (m_park[NS + j] == 0) begin
                    m_t[j] = dif_t_src[j]; m_c[j] = dif_c_src[j]; m_toe[j] = 1; m_coe[j] = 1;
                end else if (dif_mode[j] && stop) begin
                    m_t[j] = 0; m_c[j] = 0; m_toe[j] = 0; m_coe[j] = 0;
                end else begin
                    m_t[j] = 1; m_c[j] = 0; m_toe[j] = 1; m_coe[j] = 0;
                end
            end
            m_ack = stop && all_parked;
            if (m_s2 == 1) m_cnt = 0;
            else if (m_cprev0 == 0 && dif_c_src[0] && m_cnt < 2) m_cnt = m_cnt + 1;
            m_cprev0 = int'(dif_c_src[0]);
            m_s2 = m_s1;
            m_s1 = int'(pd_n);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // compare against the model every cycle, away from the edge
    always @(negedge clk) begin
        if (!rst) begin
            check(se_out == m_se, "R3/R6/R9 se_out", int'(se_out), int'(m_se));
            check({dif_t_out, dif_c_out} == {m_t, m_c}, "R4/R6/R9 pair values",
                  int'({dif_t_out, dif_c_out}), int'({m_t, m_c}));
            check({dif_t_oe, dif_c_oe} == {m_toe, m_coe}, "R4/R5 pair enables",
                  int'({dif_t_oe, dif_c_oe}), int'({m_toe, m_coe}));
            check(pd_ack == m_ack, "R2/R7 pd_ack", int'(pd_ack), int'(m_ack));
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        int ack_seen;
        wait_cycles(5);
        @(negedge clk);
        check(se_out == '0 && pd_ack == 1'b0, "R1 reset outputs", int'({se_out, pd_ack}), 0);
        check(dif_t_out == '1 && dif_t_oe == '1 && dif_c_oe == '0 && dif_c_out == '0,
              "R1 reset pairs", int'({dif_t_out, dif_t_oe, dif_c_oe}), int'({3'b111, 3'b111, 3'b000}));
        @(posedge clk); #1;
        rst = 1'b0;
        wait_cycles(60);

        // R2: short request, fewer than two qualifying edges
        pd_n = 1'b0;
        wait_cycles(3);
        pd_n = 1'b1;
        ack_seen = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (pd_ack) ack_seen = 1;
        end
        check(ack_seen == 0, "R2 short request ignored", ack_seen, 0);
        wait_cycles(20);

        // long request, all pairs true-high parking
        pd_n = 1'b0;
        wait_cycles(80);
        @(negedge clk);
        check(se_out == '0, "R3 single-ended parked low", int'(se_out), 0);
        check(pd_ack == 1'b1, "R7 acknowledge set", int'(pd_ack), 1);
        check(dif_t_out == '1 && dif_t_oe == '1 && dif_c_oe == '0, "R4 true-high park",
              int'({dif_t_out, dif_t_oe, dif_c_oe}), int'({3'b111, 3'b111, 3'b000}));
        @(posedge clk); #1;
        pd_n = 1'b1;
        wait_cycles(40);
        @(negedge clk);
        check(pd_ack == 1'b0, "R6 release clears acknowledge", int'(pd_ack), 0);

        // mixed parking modes
        @(posedge clk); #1;
        dif_mode = 3'b101;
        pd_n = 1'b0;
        wait_cycles(80);
        @(negedge clk);
        check(dif_t_oe == 3'b010 && dif_c_oe == 3'b000, "R5 undriven park",
              int'({dif_t_oe, dif_c_oe}), int'({3'b010, 3'b000}));
        @(posedge clk); #1;
        pd_n = 1'b1;
        wait_cycles(4);
        @(negedge clk);
        check(dif_t_oe == 3'b111, "R6 undriven pair driven again", int'(dif_t_oe), 7);
        wait_cycles(40);

        // disabled outputs stay parked without a request
        @(posedge clk); #1;
        se_en[1] = 1'b0;
        dif_en[2] = 1'b0;
        wait_cycles(10);
        ack_seen = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (se_out[1] || dif_c_oe[2]) ack_seen = 1;
        end
        check(ack_seen == 0, "R8 disabled outputs parked", ack_seen, 0);
        check(pd_ack == 1'b0, "R7 no acknowledge without request", int'(pd_ack), 0);
        @(posedge clk); #1;
        se_en = '1;
        dif_en = '1;
        wait_cycles(30);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule